// File: doc/BRIEF.md
# DDR2 Power-Up Initialisation Sequencer

This block is a hardware state machine that takes a DDR2 SDRAM from reset to normal operation without software. A one-cycle start pulse launches it. It first enables the PHY delay-locked loop with two control writes and waits until the PHY reports lock on both of its status flags. It then waits out the power-up interval and issues the thirteen DDR2 initialisation commands to the memory controller's command port, one strobe per command, holding back each new command until the port reports that it is no longer busy. A one-microsecond settle time follows certain commands. All waits are counted in controller clocks using a clocks-per-microsecond parameter.

The mode-register words are built from a CAS latency and a write-recovery value captured when the start pulse arrives. When the last command has been accepted, a done flag rises and stays high until reset. If the DLL never locks within a bounded number of clocks, an error flag rises and the sequence halts before any memory command.

States: `ST_IDLE` (waiting for start) goes to `ST_DLL_ON` (first PHY write), then `ST_DLL_GO` (second PHY write), then `ST_LOCK_WAIT`. From `ST_LOCK_WAIT` it goes to `ST_POWERUP` on lock or to `ST_FAULT` on timeout. `ST_POWERUP` goes to `ST_ISSUE` (command strobe), then `ST_ACCEPT` (wait for busy to clear). From `ST_ACCEPT` it goes to `ST_SETTLE` (one-microsecond wait), to `ST_ISSUE` for the next command, or to `ST_DONE` after the last one. `ST_SETTLE` goes to `ST_ISSUE`. `ST_DONE` and `ST_FAULT` are terminal.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, `phy_ctl_we_o`, `cmd_valid_o`, `done_o` and `err_o` are all low, and nothing is issued until `start_i` is seen high.
- R2: After start, exactly two PHY control writes appear on consecutive cycles. The first carries 0x00022828 (bit 17 DLL enable, bits 15:8 start point 0x28, bits 7:0 increment 0x28). The second carries 0x00032828, which is the same word with the start bit 16 added.
- R3: No memory command is issued while `phy_lock_i` is anything other than 2'b11. Lock requires both flags.
- R4: The first command strobe comes at least POWERUP_US*CLKS_PER_US clocks after lock is first seen.
- R5: Commands are issued in this order: wake-up, NOP, precharge-all, EMR2, EMR3, EMR1, MR with DLL reset, precharge-all, auto-refresh, auto-refresh, MR, EMR1 with OCD default, EMR1 with OCD exit. Every word has bit 31 set. Bits 22:20 give the kind: 0 NOP, 1 wake-up, 2 mode write, 3 precharge-all, 4 auto-refresh. For mode writes, bits 17:16 select the register: 0 MR, 1 EMR1, 2 EMR2, 3 EMR3. Bits 15:0 carry the register value, and all other bits are 0.
- R6: The MR word is 0x80200003 + CL*16 + (WR-1)*512 (burst length 8). The DLL-reset form adds bit 8 (0x100).
- R7: The EMR1 word is 0x80210006: DLL enabled (bit 0 clear), reduced drive (bit 1), 75-ohm termination (bit 2). The OCD-default form adds 0x380. The OCD-exit form adds zero, so it equals the EMR1 word.
- R8: Each strobe lasts one cycle. The next strobe is issued only after `cmd_busy_i` has been seen low on a cycle after the previous strobe. The port must raise busy on the cycle after a strobe if it needs time.
- R9: After EMR1, after both MR writes, after the second precharge-all and after each auto-refresh, the next strobe comes at least SETTLE_US*CLKS_PER_US clocks after acceptance. The other commands follow within two cycles of acceptance.
- R10: `done_o` rises on the cycle after the OCD-exit command is accepted and stays high until reset.
- R11: If lock is not seen within LOCK_TIMEOUT clocks, `err_o` rises and stays high, no memory command is issued, and `done_o` stays low.
- R12: A start pulse while a sequence is running or after it has finished has no effect: no extra command or PHY write appears, and the command stream is unchanged.
- R13: CAS latency and write recovery are captured on the start pulse. Changes to them afterwards do not alter the words issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that launches the sequence |
| cas_lat_i | input | 3 | CAS latency for the MR word |
| wr_rec_i | input | 4 | Write recovery in clocks (1..8) for the MR word |
| phy_lock_i | input | 2 | PHY lock flags; both set means locked |
| cmd_busy_i | input | 1 | Command port busy flag |
| phy_ctl_o | output | 32 | PHY DLL control word |
| phy_ctl_we_o | output | 1 | Write strobe for `phy_ctl_o` |
| cmd_word_o | output | 32 | Memory command word |
| cmd_valid_o | output | 1 | One-cycle strobe for `cmd_word_o` |
| done_o | output | 1 | Sequence complete (sticky) |
| err_o | output | 1 | DLL lock timeout (sticky) |

## Verification
The hardest situations to reach are the timing gaps, because each one is measured from a moment the bench creates itself. These are the settle gaps after acceptance, and the power-up gap after a lock that arrives only after a period with a single lock flag. The bench models the command port with a busy time that changes for each command, including zero. It timestamps the cycle in which busy is first seen low after each strobe and compares the next strobe time against a different bound depending on the command's position in the order. Separate runs cover a DLL that never locks, a start pulse and configuration change in the middle of a run, and a start pulse after completion.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DLL_ON,
        ST_DLL_GO,
        ST_LOCK_WAIT,
        ST_POWERUP,
        ST_ISSUE,
        ST_ACCEPT,
        ST_SETTLE,
        ST_DONE,
        ST_FAULT
    } seq_state_t;

    localparam int unsigned NUM_STEPS = 13;
    localparam int unsigned STEP_W    = 4;

    // PHY DLL control words
    localparam logic [31:0] PHY_DLL_ENABLE = 32'h0002_2828;
    localparam logic [31:0] PHY_DLL_START  = 32'h0003_2828;

    // command word fields
    localparam logic [31:0] CMD_FLAG      = 32'h8000_0000;
    localparam logic [31:0] KIND_NOP      = 32'h0000_0000;
    localparam logic [31:0] KIND_WAKE     = 32'h0010_0000;
    localparam logic [31:0] KIND_MODE     = 32'h0020_0000;
    localparam logic [31:0] KIND_PRECH    = 32'h0030_0000;
    localparam logic [31:0] KIND_REFRESH  = 32'h0040_0000;
    localparam logic [31:0] SEL_MR        = 32'h0000_0000;
    localparam logic [31:0] SEL_EMR1      = 32'h0001_0000;
    localparam logic [31:0] SEL_EMR2      = 32'h0002_0000;
    localparam logic [31:0] SEL_EMR3      = 32'h0003_0000;

    // register value fields
    localparam logic [31:0] MR_BURST8     = 32'h0000_0003;
    localparam logic [31:0] MR_DLL_RESET  = 32'h0000_0100;
    localparam logic [31:0] EMR_HALF_DRV  = 32'h0000_0002;
    localparam logic [31:0] EMR_TERM_75   = 32'h0000_0004;
    localparam logic [31:0] EMR_OCD_DFLT  = 32'h0000_0380;
    localparam logic [31:0] EMR_OCD_EXIT  = 32'h0000_0000;

endpackage

// File: rtl/ddr2_us_timer.sv
module ddr2_us_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/ddr2_lock_watch.sv
module ddr2_lock_watch #(
    parameter int unsigned LIMIT = 4096,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_i,
    output logic timeout_o
);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (count_i && cnt_q != LIMIT_C) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign timeout_o = (cnt_q == LIMIT_C);

    AST_WATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !clear_i) |=> timeout_o); // R11

endmodule

// File: rtl/ddr2_cmd_words.sv
module ddr2_cmd_words
    import ddr2_init_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [2:0]        cas_lat_i,
    input  logic [3:0]        wr_rec_i,
    output logic [31:0]       word_o,
    output logic              settle_o,
    output logic              last_o
);
    logic [2:0]  wr_field;
    logic [31:0] mr_word;
    logic [31:0] emr1_word;

    always_comb begin
        wr_field  = 3'(wr_rec_i - 4'd1);
        mr_word   = CMD_FLAG | KIND_MODE | SEL_MR | MR_BURST8
                  | {25'd0, cas_lat_i, 4'd0}
                  | {20'd0, wr_field, 9'd0};
        emr1_word = CMD_FLAG | KIND_MODE | SEL_EMR1 | EMR_HALF_DRV | EMR_TERM_75;
    end

    always_comb begin
        word_o   = CMD_FLAG | KIND_NOP;
        settle_o = 1'b0;
        unique case (step_i)
            4'd0:  word_o = CMD_FLAG | KIND_WAKE;
            4'd1:  word_o = CMD_FLAG | KIND_NOP;
            4'd2:  word_o = CMD_FLAG | KIND_PRECH;
            4'd3:  word_o = CMD_FLAG | KIND_MODE | SEL_EMR2;
            4'd4:  word_o = CMD_FLAG | KIND_MODE | SEL_EMR3;
            4'd5:  begin word_o = emr1_word;                settle_o = 1'b1; end
            4'd6:  begin word_o = mr_word | MR_DLL_RESET;   settle_o = 1'b1; end
            4'd7:  begin word_o = CMD_FLAG | KIND_PRECH;    settle_o = 1'b1; end
            4'd8:  begin word_o = CMD_FLAG | KIND_REFRESH;  settle_o = 1'b1; end
            4'd9:  begin word_o = CMD_FLAG | KIND_REFRESH;  settle_o = 1'b1; end
            4'd10: begin word_o = mr_word;                  settle_o = 1'b1; end
            4'd11: word_o = emr1_word | EMR_OCD_DFLT;
            4'd12: word_o = emr1_word | EMR_OCD_EXIT;
            default: word_o = CMD_FLAG | KIND_NOP;
        endcase
    end

    assign last_o = (step_i == STEP_W'(NUM_STEPS - 1));

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int unsigned CLKS_PER_US  = 200,
    parameter int unsigned POWERUP_US   = 200,
    parameter int unsigned SETTLE_US    = 1,
    parameter int unsigned LOCK_TIMEOUT = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [2:0]  cas_lat_i,
    input  logic [3:0]  wr_rec_i,
    input  logic [1:0]  phy_lock_i,
    input  logic        cmd_busy_i,
    output logic [31:0] phy_ctl_o,
    output logic        phy_ctl_we_o,
    output logic [31:0] cmd_word_o,
    output logic        cmd_valid_o,
    output logic        done_o,
    output logic        err_o
);
    localparam int unsigned PWR_CYC = POWERUP_US * CLKS_PER_US;
    localparam int unsigned SET_CYC = SETTLE_US * CLKS_PER_US;
    localparam int unsigned MAX_CYC = (PWR_CYC > SET_CYC) ? PWR_CYC : SET_CYC;
    localparam int unsigned TMR_W   = $clog2(MAX_CYC + 1);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q,  step_d;
    logic [2:0]        cl_q;
    logic [3:0]        wr_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              lock_timeout;
    logic              locked;
    logic              step_settle;
    logic              step_last;
    logic [31:0]       step_word;

    assign locked = (phy_lock_i == 2'b11);

    ddr2_us_timer #(.CNT_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    ddr2_lock_watch #(.LIMIT(LOCK_TIMEOUT)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (state_q == ST_DLL_GO),
        .count_i   (state_q == ST_LOCK_WAIT),
        .timeout_o (lock_timeout)
    );

    ddr2_cmd_words u_words (
        .step_i    (step_q),
        .cas_lat_i (cl_q),
        .wr_rec_i  (wr_q),
        .word_o    (step_word),
        .settle_o  (step_settle),
        .last_o    (step_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            cl_q    <= '0;
            wr_q    <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            if (state_q == ST_IDLE && start_i) begin
                cl_q <= cas_lat_i;
                wr_q <= wr_rec_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(SET_CYC);
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_DLL_ON;
            ST_DLL_ON:    state_d = ST_DLL_GO;
            ST_DLL_GO:    state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT: begin
                if (locked) begin
                    state_d  = ST_POWERUP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PWR_CYC);
                end else if (lock_timeout) begin
                    state_d = ST_FAULT;
                end
            end
            ST_POWERUP:   if (tmr_expired) begin
                state_d = ST_ISSUE;
                step_d  = '0;
            end
            ST_ISSUE:     state_d = ST_ACCEPT;
            ST_ACCEPT:    if (!cmd_busy_i) begin
                if (step_settle) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                end else if (step_last) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_ISSUE;
                    step_d  = step_q + 1'b1;
                end
            end
            ST_SETTLE:    if (tmr_expired) begin
                state_d = ST_ISSUE;
                step_d  = step_q + 1'b1;
            end
            ST_DONE:      state_d = ST_DONE;
            ST_FAULT:     state_d = ST_FAULT;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        phy_ctl_o    = '0;
        phy_ctl_we_o = 1'b0;
        cmd_word_o   = '0;
        cmd_valid_o  = 1'b0;
        done_o       = 1'b0;
        err_o        = 1'b0;
        unique case (state_q)
            ST_DLL_ON: begin phy_ctl_o = PHY_DLL_ENABLE; phy_ctl_we_o = 1'b1; end
            ST_DLL_GO: begin phy_ctl_o = PHY_DLL_START;  phy_ctl_we_o = 1'b1; end
            ST_ISSUE:  begin cmd_word_o = step_word;     cmd_valid_o  = 1'b1; end
            ST_DONE:   done_o = 1'b1;
            ST_FAULT:  err_o  = 1'b1;
            default:   ;
        endcase
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R8
    AST_PHY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ctl_we_o && !phy_ctl_o[16]) |=> (phy_ctl_we_o && phy_ctl_o[16])); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (err_o && !cmd_valid_o && !done_o)); // R11
    AST_FAULT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(phy_lock_i) != 2'b11)); // R3
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid_o, phy_ctl_we_o, done_o, err_o})); // R10

endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
    localparam int K    = 8;
    localparam int PWR  = 20;
    localparam int LTO  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  cas_lat_i = 3'd0;
    logic [3:0]  wr_rec_i = 4'd1;
    logic [1:0]  phy_lock_i = 2'b00;
    logic        cmd_busy_i;
    logic [31:0] phy_ctl_o, cmd_word_o;
    logic        phy_ctl_we_o, cmd_valid_o, done_o, err_o;

    ddr2_init_seq #(.CLKS_PER_US(K), .POWERUP_US(PWR), .SETTLE_US(1), .LOCK_TIMEOUT(LTO)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cas_lat_i(cas_lat_i),
        .wr_rec_i(wr_rec_i), .phy_lock_i(phy_lock_i), .cmd_busy_i(cmd_busy_i),
        .phy_ctl_o(phy_ctl_o), .phy_ctl_we_o(phy_ctl_we_o), .cmd_word_o(cmd_word_o),
        .cmd_valid_o(cmd_valid_o), .done_o(done_o), .err_o(err_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    logic [32:0] exp_q[$];
    int cmd_n = 0, phy_n = 0;
    int lock_cyc = 0, accept_cyc = 0;
    bit pending = 0;
    int busy_len = 0;
    int busy_left = 0;

    assign cmd_busy_i = (busy_left != 0);

    always @(posedge clk) begin
        if (!rst_n) busy_left <= 0;
        else if (cmd_valid_o) busy_left <= busy_len;
        else if (busy_left != 0) busy_left <= busy_left - 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit gapped(input int idx);
        return (idx >= 5 && idx <= 10);
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (pending && !cmd_busy_i) begin
                pending = 0;
                accept_cyc = cyc;
            end
            if (phy_ctl_we_o) begin
                phy_n++;
                if (exp_q.size() == 0) check(0, "R12 unexpected PHY write", phy_ctl_o, 0);
                else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    check(e[32] == 1'b1 && e[31:0] == phy_ctl_o, "R2 PHY word", phy_ctl_o, e[31:0]);
                end
            end
            if (cmd_valid_o) begin
                check(phy_lock_i == 2'b11, "R3 command before lock", {30'd0, phy_lock_i}, 32'd3);
                check(!pending && !cmd_busy_i, "R8 strobe while busy", {31'd0, cmd_busy_i}, 0);
                if (cmd_n == 0)
                    check(cyc - lock_cyc >= PWR * K, "R4 power-up gap", cyc - lock_cyc, PWR * K);
                else if (gapped(cmd_n - 1))
                    check(cyc - accept_cyc >= K, "R9 settle gap", cyc - accept_cyc, K);
                else
                    check(cyc - accept_cyc <= 2, "R9 no-settle gap", cyc - accept_cyc, 2);
                if (exp_q.size() == 0) check(0, "R12 unexpected command", cmd_word_o, 0);
                else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    check(e[32] == 1'b0 && e[31:0] == cmd_word_o, "R5 command word", cmd_word_o, e[31:0]);
                end
                cmd_n++;
                busy_len = cmd_n % 4;
                pending = 1;
            end
        end
    end

    task automatic push_seq(input logic [2:0] cl, input logic [3:0] wr);
        logic [31:0] mr, emr1;
        mr   = 32'h8020_0003 + {29'd0, cl} * 16 + ({28'd0, wr} - 1) * 512;
        emr1 = 32'h8021_0006;
        exp_q.push_back({1'b1, 32'h0002_2828});
        exp_q.push_back({1'b1, 32'h0003_2828});
        exp_q.push_back({1'b0, 32'h8010_0000});
        exp_q.push_back({1'b0, 32'h8000_0000});
        exp_q.push_back({1'b0, 32'h8030_0000});
        exp_q.push_back({1'b0, 32'h8022_0000});
        exp_q.push_back({1'b0, 32'h8023_0000});
        exp_q.push_back({1'b0, emr1});                 // R7
        exp_q.push_back({1'b0, mr + 32'h100});         // R6
        exp_q.push_back({1'b0, 32'h8030_0000});
        exp_q.push_back({1'b0, 32'h8040_0000});
        exp_q.push_back({1'b0, 32'h8040_0000});
        exp_q.push_back({1'b0, mr});                   // R6
        exp_q.push_back({1'b0, emr1 + 32'h380});       // R7
        exp_q.push_back({1'b0, emr1});                 // R7
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; phy_lock_i = 2'b00; start_i = 1'b0;
        exp_q.delete(); cmd_n = 0; phy_n = 0; pending = 0; busy_len = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_seq(input logic [2:0] cl, input logic [3:0] wr, input bit disturb);
        int partial_cmds;
        push_seq(cl, wr);
        cas_lat_i = cl; wr_rec_i = wr;
        pulse_start();
        cas_lat_i = ~cl; wr_rec_i = 4'd8;        // R13 late change
        while (phy_n < 2) @(negedge clk);
        phy_lock_i = 2'b01;
        partial_cmds = cmd_n;
        repeat (20) @(negedge clk);
        check(cmd_n == partial_cmds, "R3 single flag held off", cmd_n, partial_cmds);
        phy_lock_i = 2'b11;
        lock_cyc = cyc;
        if (disturb) begin
            repeat (PWR * K + 5) @(negedge clk);
            pulse_start();                        // R12 start while running
        end
        while (!done_o && cmd_n < 20 && cyc < 90000) @(negedge clk);
        check(cmd_n == 13, "R5 command count", cmd_n, 13);
        check(accept_cyc == cyc - 1 || accept_cyc == cyc, "R10 done timing", cyc - accept_cyc, 1);
        check(done_o && exp_q.size() == 0, "R10 done after OCD exit", {31'd0, done_o}, 1);
    endtask

    initial begin
        do_reset();
        check(!phy_ctl_we_o && !cmd_valid_o && !done_o && !err_o, "R1 reset outputs",
              {28'd0, phy_ctl_we_o, cmd_valid_o, done_o, err_o}, 0);
        repeat (10) @(negedge clk);
        check(phy_n == 0 && cmd_n == 0, "R1 idle without start", phy_n + cmd_n, 0);

        run_seq(3'd6, 4'd6, 1'b1);
        pulse_start();                            // R12 start after done
        repeat (60) @(negedge clk);
        check(done_o && cmd_n == 13 && phy_n == 2, "R12 start after done ignored", cmd_n, 13);
        check(done_o, "R10 done sticky", {31'd0, done_o}, 1);

        do_reset();
        run_seq(3'd5, 4'd4, 1'b0);

        do_reset();
        exp_q.push_back({1'b1, 32'h0002_2828});
        exp_q.push_back({1'b1, 32'h0003_2828});
        pulse_start();
        phy_lock_i = 2'b10;
        repeat (LTO + 10) @(negedge clk);
        check(err_o == 1'b1, "R11 timeout error", {31'd0, err_o}, 1);
        check(!done_o && cmd_n == 0, "R11 no commands after fault", cmd_n, 0);
        phy_lock_i = 2'b11;
        repeat (30) @(negedge clk);
        check(err_o && cmd_n == 0, "R11 halted after late lock", cmd_n, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule